// File: doc/BRIEF.md
# Hash-Based Receive Load Filter

This block sits on the receive side of one node in a group of peers that share incoming work without a central dispatcher. Every node sees every broadcast request. Each node folds the request's 32-bit source address into a 4-bit bucket number and keeps only the requests whose bucket it has been given. Requests that belong to other buckets are dropped without any further action. The peers hold complementary bucket assignments, so every request is taken by exactly one node.

The assignment is a 16-bit ownership mask with one bit per bucket. Software writes it as a single word. When a peer fails, the surviving nodes receive new masks that share out the failed peer's buckets. A new mask does not apply at once. It is held aside and installed only when no request is in the pipeline. A request already in flight therefore finishes on the mask that was live when it arrived.

Each bucket has a saturating counter of accepted requests, read through a select port. The accept/drop decision comes out exactly two clock cycles after the request strobe.

Top module: `hash_rx_filter`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid` and `dec_accept` are 0, every bucket counter reads 0 and the ownership mask is all zeros, so every request is dropped.
- R2: The bucket of a request is the XOR of the eight 4-bit slices of `req_src`: bits 3:0, 7:4, and so on up to 31:28.
- R3: A request sampled with `req_valid` high at clock edge k gives `dec_valid` high after edge k+2 for exactly one cycle, with `dec_bucket` set to its bucket. `dec_valid` is never high otherwise.
- R4: `dec_accept` equals bit b of the live ownership mask, where b is the request's bucket (bit 0 is bucket 0). A 0 bit drops the request.
- R5: A mask written with `own_wr` at edge e is installed at the first edge after e at which `req_valid` is low and no request sampled at the previous edge is still pending. Until then, requests are decided on the old mask. A single idle cycle after a request therefore delays installation by one more cycle.
- R6: If several writes arrive before installation, the most recent mask is the one installed.
- R7: Each accepted decision adds one to its bucket's counter, in the same edge that raises `dec_valid`. Dropped requests leave every counter unchanged.
- R8: A counter at its all-ones value stays there on further accepts.
- R9: `cnt_val` shows, combinationally, the counter of the bucket selected by `cnt_sel`.
- R10: `dec_accept` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_src | input | 32 | Source address of the request |
| own_wr | input | 1 | Write strobe for a new ownership mask |
| own_mask | input | 16 | New ownership mask, bit b owns bucket b |
| cnt_sel | input | 4 | Bucket whose counter is read |
| cnt_val | output | CNT_W | Accept count of the selected bucket |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = keep the request, 0 = drop it |
| dec_bucket | output | 4 | Bucket of the decided request |

## Verification
A wrong fold, or a wrong mask bit, appears on the very next decision for an address in that bucket, two cycles after the strobe. It shows as a bad `dec_bucket` or an inverted `dec_accept`.

A mask that is installed too early or too late is harder to see. It shows only on the requests at the edges of a back-to-back stream that overlaps a write, so those requests are compared one by one.

A counter fault appears only when the counter is read. The counters are therefore swept after each phase and compared against a count kept from every accepted decision.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the hash receive filter.
// Assumes: nothing beyond the standard language.
package hrf_pkg;
    // State of a mask update waiting to be installed
    typedef enum logic {
        MASK_IDLE = 1'b0,
        MASK_PEND = 1'b1
    } mask_state_e;
endpackage

// File: rtl/hrf_hash.sv
`timescale 1ns/1ps
// XOR-folds an address into a bucket number, one slice at a time.
// Assumes: ADDR_W is a whole multiple of BKT_W.
module hrf_hash #(
    parameter int ADDR_W = 32,
    parameter int BKT_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BKT_W-1:0]  bucket
);
    localparam int NSLICE = ADDR_W / BKT_W;

    logic [BKT_W-1:0] part [NSLICE];

    assign part[0] = addr[BKT_W-1:0];

    // Chain of partial XORs across the address slices
    for (genvar g = 1; g < NSLICE; g++) begin : g_fold
        assign part[g] = part[g-1] ^ addr[g*BKT_W +: BKT_W];
    end

    assign bucket = part[NSLICE-1];
endmodule

// File: rtl/hrf_own_table.sv
`timescale 1ns/1ps
// Holds the live bucket-ownership mask and a shadow copy.
// A written mask waits in the shadow and is copied to the live mask only
// in a cycle where the pipeline reports no request in flight.
// Assumes: busy is high whenever a request is being sampled or looked up.
module hrf_own_table #(
    parameter int NBKT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NBKT-1:0] wr_mask,
    input  logic            busy,
    output logic [NBKT-1:0] live,
    output logic            pend
);
    import hrf_pkg::*;

    mask_state_e     state;
    logic [NBKT-1:0] shadow;
    logic            commit;

    // A pending mask may be installed only when the pipeline is empty
    assign commit = (state == MASK_PEND) && !busy;
    assign pend   = (state == MASK_PEND);

    // Shadow capture, install and pending-state tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            shadow <= '0;
            state  <= MASK_IDLE;
        end else begin
            if (commit)
                live <= shadow;
            if (wr_en) begin
                shadow <= wr_mask;
                state  <= MASK_PEND;
            end else if (commit) begin
                state  <= MASK_IDLE;
            end
        end
    end
endmodule

// File: rtl/hrf_bucket_counters.sv
`timescale 1ns/1ps
// One saturating accept counter per bucket, plus a read multiplexer.
// Assumes: at most one increment per cycle.
module hrf_bucket_counters #(
    parameter int NBKT  = 16,
    parameter int BKT_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [BKT_W-1:0] inc_bkt,
    input  logic [BKT_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NBKT];

    for (genvar b = 0; b < NBKT; b++) begin : g_cnt
        // Count accepted requests for bucket b, holding at the maximum
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[b] <= '0;
            else if (inc_en && (inc_bkt == BKT_W'(b)) && (cnt[b] != CNT_MAX))
                cnt[b] <= cnt[b] + 1'b1;
        end
    end

    assign rd_val = cnt[rd_sel];
endmodule

// File: rtl/hash_rx_filter.sv
`timescale 1ns/1ps
// Per-node receive filter for hash-shared broadcast traffic.
// Stage 1 registers the folded bucket. Stage 2 looks up the live ownership
// mask, registers the decision and bumps the bucket counter.
// Assumes: one request per strobe, addresses ADDR_W bits wide.
module hash_rx_filter #(
    parameter int ADDR_W = 32,
    parameter int BKT_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_src,
    input  logic              own_wr,
    input  logic [(1<<BKT_W)-1:0] own_mask,
    input  logic [BKT_W-1:0]  cnt_sel,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [BKT_W-1:0]  dec_bucket
);
    localparam int NBKT = 1 << BKT_W;

    logic [BKT_W-1:0] hash_bkt;
    logic             s1_valid;
    logic [BKT_W-1:0] s1_bkt;
    logic [NBKT-1:0]  tbl_live;
    logic             tbl_pend;
    logic             busy;
    logic             hit;

    hrf_hash #(.ADDR_W(ADDR_W), .BKT_W(BKT_W)) u_hash (
        .addr   (req_src),
        .bucket (hash_bkt)
    );

    assign busy = req_valid | s1_valid;

    hrf_own_table #(.NBKT(NBKT)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (own_wr),
        .wr_mask (own_mask),
        .busy    (busy),
        .live    (tbl_live),
        .pend    (tbl_pend)
    );

    assign hit = s1_valid & tbl_live[s1_bkt];

    // Stage 1: capture strobe and bucket
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_bkt   <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_bkt   <= hash_bkt;
        end
    end

    // Stage 2: register the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_bucket <= '0;
        end else begin
            dec_valid  <= s1_valid;
            dec_accept <= hit;
            dec_bucket <= s1_bkt;
        end
    end

    hrf_bucket_counters #(.NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (hit),
        .inc_bkt (s1_bkt),
        .rd_sel  (cnt_sel),
        .rd_val  (cnt_val)
    );
endmodule

// File: rtl/hrf_chk.sv
`timescale 1ns/1ps
// Timing and mask-installation properties of the receive filter.
// Assumes: bound to hash_rx_filter; req_valid is low while reset is held.
module hrf_chk #(
    parameter int NBKT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            s1_valid,
    input logic            dec_valid,
    input logic            dec_accept,
    input logic [NBKT-1:0] tbl_live,
    input logic            tbl_pend
);
    // R3
    dec_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid, 2) |-> dec_valid);

    // R3
    dec_has_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(req_valid, 2));

    // R10
    accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    // R5
    mask_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || s1_valid) |=> $stable(tbl_live));

    // R5
    mask_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tbl_live) |-> $past(tbl_pend));
endmodule

bind hash_rx_filter hrf_chk #(.NBKT(NBKT)) u_hrf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .s1_valid   (s1_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .tbl_live   (tbl_live),
    .tbl_pend   (tbl_pend)
);

// File: tb/test_hash_rx_filter.sv
`timescale 1ns/1ps
module test_hash_rx_filter;
    localparam int CLK_P = 10;
    localparam int CW    = 4;
    localparam int NV    = 12;
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_000F,
        32'hF000_0000, 32'hDEAD_BEEF, 32'h8000_0001, 32'h1111_1111,
        32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'hCAFE_F00D, 32'h7654_3210};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_src = '0;
    logic          own_wr = 1'b0;
    logic [15:0]   own_mask = '0;
    logic [3:0]    cnt_sel = '0;
    logic [CW-1:0] cnt_val;
    logic          dec_valid, dec_accept;
    logic [3:0]    dec_bucket;

    int checks = 0;
    int errors = 0;

    // Reference state kept from the requirements
    logic [15:0]   m_live, m_shadow;
    logic          m_pend;
    logic [CW-1:0] m_cnt [16];
    logic          e1_v, e2_v, e2_acc;
    logic [3:0]    e1_b, e2_b;

    hash_rx_filter #(.ADDR_W(32), .BKT_W(4), .CNT_W(CW)) i_hash_rx_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .own_wr(own_wr), .own_mask(own_mask), .cnt_sel(cnt_sel),
        .cnt_val(cnt_val), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_bucket(dec_bucket));

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] fold(input logic [31:0] a);
        logic [3:0] r = 4'h0;
        for (int i = 0; i < 8; i++) r = r ^ a[4*i +: 4];
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_live = '0; m_shadow = '0; m_pend = 1'b0;
        e1_v = 1'b0; e2_v = 1'b0; e2_acc = 1'b0; e1_b = '0; e2_b = '0;
        for (int b = 0; b < 16; b++) m_cnt[b] = '0;
    endtask

    // One cycle: check the decision now showing, then drive the next edge
    task automatic tick(input logic rq, input logic [31:0] a,
                        input logic wr, input logic [15:0] mk, input string tag);
        @(negedge clk);
        check("R3 dec_valid", int'(dec_valid), int'(e2_v));
        if (e2_v) begin
            check("R2 dec_bucket", int'(dec_bucket), int'(e2_b));
            check({tag, " dec_accept"}, int'(dec_accept), int'(e2_acc));
        end else begin
            check("R10 accept idle", int'(dec_accept), 0);
        end
        // Reference update for the coming edge
        e2_v = e1_v; e2_b = e1_b; e2_acc = e1_v & m_live[e1_b];
        if (e2_acc && m_cnt[e1_b] != '1) m_cnt[e1_b] = m_cnt[e1_b] + 1'b1;
        if (m_pend && !rq && !e1_v) begin
            m_live = m_shadow;
            m_pend = 1'b0;
        end
        if (wr) begin
            m_shadow = mk;
            m_pend = 1'b1;
        end
        e1_v = rq; e1_b = fold(a);
        req_valid = rq; req_src = a; own_wr = wr; own_mask = mk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, '0, "R4");
    endtask

    task automatic check_counters(input string tag);
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            cnt_sel = 4'(b);
            #1;
            check(tag, int'(cnt_val), int'(m_cnt[b]));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; own_wr = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state at the ports
        #1;
        check("R1 dec_valid", int'(dec_valid), 0);
        check("R1 dec_accept", int'(dec_accept), 0);
        check_counters("R1 counter");
        // R1: zero mask drops everything
        for (int i = 0; i < 4; i++) tick(1'b1, VEC[i], 1'b0, '0, "R1");
        idle(3);

        // Vector walk under a fixed mask (R2, R4)
        tick(1'b0, '0, 1'b1, 16'hA5C3, "R4");
        idle(2);
        for (int i = 0; i < NV; i++) tick(1'b1, VEC[i], 1'b0, '0, "R4");
        idle(3);
        check_counters("R7 counter");
        check_counters("R9 read");

        // R5: write during a back-to-back stream is held off
        for (int i = 0; i < 6; i++)
            tick(1'b1, VEC[i+3], (i == 2), 16'h5A3C, "R5");
        tick(1'b0, '0, 1'b0, '0, "R5");
        tick(1'b1, VEC[0], 1'b0, '0, "R5");
        idle(3);
        for (int i = 0; i < NV; i++) tick(1'b1, VEC[i], 1'b0, '0, "R5");
        idle(3);

        // R6: two writes before installation, the second wins
        tick(1'b1, VEC[5], 1'b1, 16'hFFFF, "R6");
        tick(1'b1, VEC[6], 1'b1, 16'h0F0F, "R6");
        idle(3);
        for (int i = 0; i < NV; i++) tick(1'b1, VEC[i], 1'b0, '0, "R6");
        idle(3);
        check_counters("R7 counter");

        // R8: saturation of bucket 0
        tick(1'b0, '0, 1'b1, 16'hFFFF, "R8");
        idle(2);
        for (int i = 0; i < 20; i++) tick(1'b1, 32'h0000_0000, 1'b0, '0, "R8");
        idle(3);
        check_counters("R8 saturate");

        // R1: reset mid-run clears counters and mask
        do_reset();
        #1;
        check("R1 dec_valid", int'(dec_valid), 0);
        check_counters("R1 counter");
        for (int i = 0; i < 4; i++) tick(1'b1, VEC[i], 1'b0, '0, "R1");
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule